// File: doc/BRIEF.md
# PCI Interrupt Link Router

This block steers eight shared PCI interrupt links onto a 16-line ISA-style IRQ vector. Every link owns a small routing byte that holds a disable flag and a 4-bit IRQ selector. Software reaches these bytes through a flat read/write port that is indexed by link number. Several devices share each link through level-sensitive request inputs. The link counts as active while any one of those requests is high.

An active link drives the IRQ line that its routing byte selects, but only when the byte is enabled and names a permitted IRQ. Selectors that point at reserved IRQ numbers are treated as disabled, and nothing is reported about it. A link can be reprogrammed while it is active. In that case the level moves from the old line to the new one on a single clock edge. Links that select the same IRQ are ORed together. The IRQ vector is registered, so it changes only on clock edges.

Top module: `pirq_router`

## Requirements
- R1: After reset every routing byte reads 0x80 (disabled), and every bit of `irq_o` is low.
- R2: A write stores only bit 7 (disable) and bits 3:0 (selector), which is data AND 0x8F. Bits 6:4 always read as zero. `reg_rdata_o` shows the byte of link `reg_idx_i` combinationally.
- R3: A link whose bit 7 is set drives no IRQ line, whatever its requests are doing.
- R4: Selector values 0, 1, 2, 8 and 13 are reserved, so the permitted mask is 0xDEF8. A link that selects a reserved value drives nothing, exactly as if it were disabled. Reserved bits of `irq_o` are never high.
- R5: Link k uses requests `src_req_i[4k+3:4k]`. Its line goes high when the first request rises and stays high until the last request falls.
- R6: An enabled, permitted, active link drives `irq_o` bit N, where N is its selector. `irq_o` shows a request change on the next clock edge, and it shows a register write one edge after the edge that performs the write.
- R7: Rewriting an active link to a different valid selector drops the old line and raises the new line in the same cycle.
- R8: Each `irq_o` bit is the OR of every link that currently drives it.
- R9: Rewriting a link with its current value leaves `irq_o` unchanged in every cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_idx_i | input | 3 | Link index for read and write |
| reg_we_i | input | 1 | Write strobe |
| reg_wdata_i | input | 8 | Write data |
| reg_rdata_o | output | 8 | Routing byte of the indexed link |
| src_req_i | input | 32 | Level requests, four per link |
| irq_o | output | 16 | IRQ line vector |

## Verification
The bench walks through every reserved selector on an active link. A design that applied the mask wrongly would raise lines 0, 1, 2, 8 or 13. It also moves an active link to a new selector and checks that the old line falls in the same cycle that the new line rises. A faulty design would leave both lines high, or neither. Shared-request release order is exercised so that a line which drops on the first falling request is caught. A same-value rewrite is watched cycle by cycle to catch a one-cycle dropout. Random writes and request toggles are then compared against a bench model of the OR of all routed links.

// File: rtl/pirq_pkg.sv
package pirq_pkg;
  localparam int unsigned CFG_W     = 8;
  localparam int unsigned DIS_BIT   = 7;
  localparam logic [CFG_W-1:0] CFG_RST = 8'h80;
endpackage

// File: rtl/pirq_link_regs.sv
module pirq_link_regs
  import pirq_pkg::*;
#(
  parameter int unsigned NUM_LINKS = 8,
  parameter int unsigned SEL_W     = 4,
  localparam int unsigned IDX_W    = $clog2(NUM_LINKS)
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic [IDX_W-1:0]           reg_idx_i,
  input  logic                       reg_we_i,
  input  logic [CFG_W-1:0]           reg_wdata_i,
  output logic [CFG_W-1:0]           reg_rdata_o,
  output logic [NUM_LINKS-1:0]       dis_o,
  output logic [NUM_LINKS-1:0][SEL_W-1:0] sel_o
);
  localparam int unsigned PAD_W = CFG_W - 1 - SEL_W;

  logic [NUM_LINKS-1:0]            dis_q;
  logic [NUM_LINKS-1:0][SEL_W-1:0] sel_q;
  logic                            idx_ok;
  logic                            unused_wbits;

  assign idx_ok       = 32'(reg_idx_i) < NUM_LINKS;
  assign unused_wbits = ^reg_wdata_i[DIS_BIT-1:SEL_W];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dis_q <= '1;
      sel_q <= '0;
    end else if (reg_we_i && idx_ok) begin
      dis_q[reg_idx_i] <= reg_wdata_i[DIS_BIT];
      sel_q[reg_idx_i] <= reg_wdata_i[SEL_W-1:0];
    end
  end

  always_comb begin
    reg_rdata_o = '0;
    if (idx_ok) reg_rdata_o = {dis_q[reg_idx_i], {PAD_W{1'b0}}, sel_q[reg_idx_i]};
  end

  assign dis_o = dis_q;
  assign sel_o = sel_q;

  AST_WR_KEEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_we_i && idx_ok) |=> ({dis_q[$past(reg_idx_i)], sel_q[$past(reg_idx_i)]} ==
                              {$past(reg_wdata_i[DIS_BIT]), $past(reg_wdata_i[SEL_W-1:0])})); // R2
  AST_NO_WR_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !reg_we_i |=> ($stable(dis_q) && $stable(sel_q))); // R9
endmodule

// File: rtl/pirq_link_decode.sv
module pirq_link_decode #(
  parameter int unsigned NUM_SRC     = 4,
  parameter int unsigned NUM_IRQ     = 16,
  parameter logic [NUM_IRQ-1:0] PERMIT = 16'hDEF8,
  localparam int unsigned SEL_W      = $clog2(NUM_IRQ)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               dis_i,
  input  logic [SEL_W-1:0]   sel_i,
  input  logic [NUM_SRC-1:0] src_i,
  output logic [NUM_IRQ-1:0] line_o
);
  logic active, routable;

  // any sharing source keeps the link up
  assign active   = |src_i;
  // reserved numbers fold into the disabled case
  assign routable = !dis_i && PERMIT[sel_i];

  always_comb begin
    line_o = '0;
    if (active && routable) line_o[sel_i] = 1'b1;
  end

  AST_LINE_ONEHOT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(line_o)); // R6
  AST_DIS_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dis_i |-> (line_o == '0)); // R3
  AST_IDLE_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (src_i == '0) |-> (line_o == '0)); // R5
endmodule

// File: rtl/pirq_irq_merge.sv
module pirq_irq_merge #(
  parameter int unsigned NUM_LINKS   = 8,
  parameter int unsigned NUM_IRQ     = 16,
  parameter logic [NUM_IRQ-1:0] PERMIT = 16'hDEF8
) (
  input  logic                              clk_i,
  input  logic                              rst_ni,
  input  logic [NUM_LINKS-1:0][NUM_IRQ-1:0] lines_i,
  output logic [NUM_IRQ-1:0]                irq_o
);
  logic [NUM_IRQ-1:0] irq_d, irq_q;

  always_comb begin
    irq_d = '0;
    for (int k = 0; k < NUM_LINKS; k++) irq_d |= lines_i[k];
  end

  // single register stage: an old/new line swap lands on one edge
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) irq_q <= '0;
    else         irq_q <= irq_d;
  end

  assign irq_o = irq_q;

  AST_RSVD_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_q & ~PERMIT) == '0); // R4

  for (genvar k = 0; k < NUM_LINKS; k++) begin : g_reach
    AST_LINK_REACHES: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (|lines_i[k]) |=> ((irq_q & $past(lines_i[k])) == $past(lines_i[k]))); // R8
  end
endmodule

// File: rtl/pirq_router.sv
module pirq_router
  import pirq_pkg::*;
#(
  parameter int unsigned NUM_LINKS   = 8,
  parameter int unsigned NUM_SRC     = 4,
  parameter int unsigned NUM_IRQ     = 16,
  parameter logic [NUM_IRQ-1:0] PERMIT = 16'hDEF8,
  localparam int unsigned IDX_W      = $clog2(NUM_LINKS),
  localparam int unsigned SEL_W      = $clog2(NUM_IRQ),
  localparam int unsigned REQ_W      = NUM_LINKS * NUM_SRC
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [IDX_W-1:0]   reg_idx_i,
  input  logic               reg_we_i,
  input  logic [CFG_W-1:0]   reg_wdata_i,
  output logic [CFG_W-1:0]   reg_rdata_o,
  input  logic [REQ_W-1:0]   src_req_i,
  output logic [NUM_IRQ-1:0] irq_o
);
  logic [NUM_LINKS-1:0]              dis;
  logic [NUM_LINKS-1:0][SEL_W-1:0]   sel;
  logic [NUM_LINKS-1:0][NUM_IRQ-1:0] lines;

  pirq_link_regs #(.NUM_LINKS(NUM_LINKS), .SEL_W(SEL_W)) u_regs (
    .clk_i, .rst_ni, .reg_idx_i, .reg_we_i, .reg_wdata_i, .reg_rdata_o,
    .dis_o(dis), .sel_o(sel)
  );

  for (genvar k = 0; k < NUM_LINKS; k++) begin : g_link
    pirq_link_decode #(.NUM_SRC(NUM_SRC), .NUM_IRQ(NUM_IRQ), .PERMIT(PERMIT)) u_dec (
      .clk_i, .rst_ni,
      .dis_i (dis[k]),
      .sel_i (sel[k]),
      .src_i (src_req_i[k*NUM_SRC +: NUM_SRC]),
      .line_o(lines[k])
    );
  end

  pirq_irq_merge #(.NUM_LINKS(NUM_LINKS), .NUM_IRQ(NUM_IRQ), .PERMIT(PERMIT)) u_merge (
    .clk_i, .rst_ni, .lines_i(lines), .irq_o
  );

  AST_RESET_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rst_ni) |-> (irq_o == '0)); // R1
endmodule

// File: tb/sim_pirq_router.sv
module sim_pirq_router;
  localparam logic [15:0] PERM = 16'hDEF8;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [2:0]  idx = '0;
  logic        we = 1'b0;
  logic [7:0]  wdata = '0;
  logic [7:0]  rdata;
  logic [31:0] src = '0;
  logic [15:0] irq;

  logic [7:0] sh_cfg [8];
  int errors = 0;
  int checks = 0;
  int cycles = 0;

  always #2 clk = ~clk;

  pirq_router u0 (
    .clk_i(clk), .rst_ni(rst_n), .reg_idx_i(idx), .reg_we_i(we),
    .reg_wdata_i(wdata), .reg_rdata_o(rdata), .src_req_i(src), .irq_o(irq)
  );

  function automatic logic [15:0] exp_irq();
    logic [15:0] v = '0;
    for (int l = 0; l < 8; l++)
      if (src[l*4 +: 4] != 4'h0 && !sh_cfg[l][7] && PERM[sh_cfg[l][3:0]])
        v[sh_cfg[l][3:0]] = 1'b1;
    return v;
  endfunction

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  task automatic wr(input int l, input logic [7:0] v);
    @(negedge clk);
    idx = 3'(l); wdata = v; we = 1'b1;
    @(negedge clk);
    we = 1'b0;
    sh_cfg[l] = v & 8'h8F;
  endtask

  task automatic settle();
    @(posedge clk); @(posedge clk); @(negedge clk);
  endtask

  task automatic rd(input string req, input int l);
    idx = 3'(l);
    #1;
    chk(req, {8'h00, rdata}, {8'h00, sh_cfg[l]});
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=%0d expected<100000", cycles);
      finish_run();
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    for (int l = 0; l < 8; l++) sh_cfg[l] = 8'h80;
    @(negedge clk);
    chk("R1 irq in reset", irq, 16'h0);
    @(negedge clk); rst_n = 1'b1;
    @(negedge clk);
    for (int l = 0; l < 8; l++) rd("R1 reset byte", l);
    chk("R1 irq after reset", irq, 16'h0);

    // R2 masking
    wr(0, 8'hFF); rd("R2 mask 0xFF", 0);
    wr(0, 8'h75); rd("R2 mask 0x75", 0);

    // R6 / R5 basic routing and sharing
    wr(0, 8'h05);
    @(negedge clk); src[0] = 1'b1; settle();
    chk("R6 route to 5", irq, exp_irq());
    src[1] = 1'b1; settle(); src[0] = 1'b0; settle();
    chk("R5 second source holds", irq, 16'h0020);
    src[1] = 1'b0; settle();
    chk("R5 last release drops", irq, 16'h0000);

    // R3 disable
    src[2] = 1'b1;
    wr(0, 8'h85); settle();
    chk("R3 disabled link quiet", irq, 16'h0000);

    // R4 reserved selectors
    begin
      int rsv[5] = '{0, 1, 2, 8, 13};
      foreach (rsv[i]) begin
        wr(0, 8'(rsv[i])); settle();
        chk("R4 reserved selector", irq, 16'h0000);
      end
    end
    wr(0, 8'h80); src[3:0] = 4'h0;

    // R7 live move
    wr(1, 8'h04);
    @(negedge clk); src[4] = 1'b1; settle();
    chk("R7 before move", irq, 16'h0010);
    wr(1, 8'h0A);
    @(posedge clk); @(negedge clk);
    chk("R7 moved same cycle", irq, 16'h0400);

    // R8 shared IRQ between links
    wr(2, 8'h0A);
    @(negedge clk); src[9] = 1'b1; settle();
    src[4] = 1'b0; settle();
    chk("R8 other link keeps line", irq, 16'h0400);

    // R9 identical rewrite
    @(negedge clk);
    idx = 3'd2; wdata = 8'h0A; we = 1'b1;
    for (int c = 0; c < 4; c++) begin
      @(negedge clk);
      we = 1'b0;
      chk("R9 no glitch", irq, 16'h0400);
    end

    // random mix
    for (int n = 0; n < 400; n++) begin
      if ($urandom_range(0, 2) == 0) wr($urandom_range(0, 7), 8'($urandom()));
      else begin @(negedge clk); src[$urandom_range(0, 31)] ^= 1'b1; end
      settle();
      chk("R6 R8 random irq", irq, exp_irq());
      rd("R2 random readback", $urandom_range(0, 7));
    end

    finish_run();
  end
endmodule